// File: doc/BRIEF.md
# Single-Channel Memory-to-Memory DMA with Non-Maskable Suspend

This block is one DMA channel that copies a run of bytes or 16-bit words from a source address to a destination address. Each unit is one read cycle followed by one write cycle on a simple ready-handshaked bus. Software programs the channel through a small register port with four locations: source pointer, destination pointer, unit count and a control word. Before it touches the bus, the channel asks the CPU for it with a request/grant handshake.

The channel runs in one of two modes. In burst mode it keeps the bus until the count is used up. In cycle-steal mode it gives the bus back after every unit and asks again for the next one. The channel moves data only while two enables are both set: a channel enable and a master enable.

A non-maskable interrupt input suspends a burst cleanly. It clears the master enable, lets the unit in flight finish, drops the bus request and keeps the pointers and the count. Software sees a suspended channel as channel enable 1 with master enable 0. Writing the master enable back to 1 continues the copy where it stopped. In cycle-steal mode the interrupt input is ignored.

Top module: `dma_burst_chan`

## Requirements
- R1: Register map, selected by `reg_addr`: 0 = source pointer, 1 = destination pointer, 2 = remaining unit count, 3 = control. Control bits are: bit0 word size (1 = 16-bit, 0 = byte in data bits 7:0), bit1 burst (1) or cycle-steal (0), bit2 source increment, bit3 destination increment, bit4 channel enable, bit5 master enable. A write lands on the next clock edge, and `reg_rdata` shows the addressed register combinationally.
- R2: The bus request rises only when channel enable and master enable are both 1 and the count is nonzero. With master enable 0 the channel stays off the bus.
- R3: While burst mode is set, `nmi` high on a clock edge clears master enable. This takes priority over a register write in the same cycle.
- R4: While cycle-steal mode is set, `nmi` changes neither enable, and the transfer runs to completion.
- R5: When master enable is 0 during a burst, the unit in flight finishes both its read and its write. The bus request then drops, and no further read or write occurs.
- R6: A suspended channel reads back with channel enable 1, master enable 0, and a count equal to the programmed count minus the units already written.
- R7: Writing master enable 1 to a suspended channel resumes the copy from the saved pointers and count. The destination ends up holding the complete copy.
- R8: After each unit, a pointer whose increment bit is set advances by 1 for bytes or 2 for words. A pointer whose increment bit is clear stays fixed.
- R9: When the last unit's write completes, the count reads 0 and channel enable clears. `done` is high for exactly one cycle, and master enable is left unchanged.
- R10: No read starts before `bus_gnt` is seen high. Each read and write cycle holds its address and strobe until `bus_rdy` is high.
- R11: If `nmi` arrives in burst mode in the same cycle as the last unit's completing write, the copy still finishes and `done` pulses, and master enable ends at 0.
- R12: In cycle-steal mode the bus request falls after every unit and rises again for the next one, one request per unit. In burst mode it rises once per uninterrupted run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register |
| nmi | input | 1 | Non-maskable interrupt request |
| bus_req | output | 1 | Bus request to the CPU |
| bus_gnt | input | 1 | Bus grant from the CPU |
| bus_addr | output | AW (16) | Bus address |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_word | output | 1 | 1 = 16-bit access, 0 = byte access |
| bus_wdata | output | DW (16) | Write data |
| bus_rdata | input | DW (16) | Read data |
| bus_rdy | input | 1 | Ends the current read or write cycle |
| done | output | 1 | One-cycle pulse when the count reaches zero |

## Verification
A register write is visible at `reg_rdata` one edge later. The bus request rises on the second edge after a control write enables the channel. The first read follows on the edge after grant is seen. Each unit then takes one read edge and one write edge, plus any cycles held off by `bus_rdy`, and `done` rises on the edge after the final write's ready. Because these latencies stretch with waits and grant delay, the bench never counts fixed cycles for transfer results. It waits at falling edges for the event in question (done, a given number of completed writes, the final write with count 1), then samples outputs and register readback at that falling edge. Read and write handshakes, request rises and `done` pulses are tallied at rising edges, so each check compares totals against counts derived from the programmed vector.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_REQ,
    SQ_RD,
    SQ_WR
  } seq_state_t;

  // Bit 5 down to bit 0 of the control register.
  typedef struct packed {
    logic mst_en;
    logic ch_en;
    logic dst_inc;
    logic src_inc;
    logic burst;
    logic wide;
  } chan_ctrl_t;

  localparam int CTRL_W = 6;

  localparam logic [1:0] OFS_SRC  = 2'd0;
  localparam logic [1:0] OFS_DST  = 2'd1;
  localparam logic [1:0] OFS_CNT  = 2'd2;
  localparam logic [1:0] OFS_CTRL = 2'd3;

endpackage

// File: rtl/dma_ctrl_regs.sv
module dma_ctrl_regs
  import dma_chan_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  input  logic              nmi,
  input  logic              last_done,
  output chan_ctrl_t        ctrl
);

  chan_ctrl_t ctrl_q, ctrl_n;

  always_comb begin
    ctrl_n = ctrl_q;
    if (wr_en)
      ctrl_n = chan_ctrl_t'(wr_data);
    if (last_done)
      ctrl_n.ch_en = 1'b0;
    if (nmi && ctrl_q.burst)
      ctrl_n.mst_en = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ctrl_q <= '0;
    else
      ctrl_q <= ctrl_n;
  end

  assign ctrl = ctrl_q;

  // R3: burst-mode interrupt removes the master enable
  a_r3_nmi_clears_master: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi && ctrl_q.burst) |=> !ctrl_q.mst_en);

  // R4: cycle-steal mode is deaf to the interrupt
  a_r4_nmi_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi && !ctrl_q.burst && !wr_en) |=> (ctrl_q.mst_en == $past(ctrl_q.mst_en)));

  // R9: completion drops the channel enable but keeps the master enable
  a_r9_chan_en_clears: assert property (@(posedge clk) disable iff (!rst_n)
    last_done |=> !ctrl_q.ch_en);

  a_r9_master_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (last_done && !wr_en && !nmi) |=> (ctrl_q.mst_en == $past(ctrl_q.mst_en)));

endmodule

// File: rtl/dma_addr_path.sv
module dma_addr_path #(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_src,
  input  logic          wr_dst,
  input  logic          wr_cnt,
  input  logic [31:0]   wr_data,
  input  logic          unit_done,
  input  logic          wide,
  input  logic          src_inc,
  input  logic          dst_inc,
  output logic [AW-1:0] src,
  output logic [AW-1:0] dst,
  output logic [CW-1:0] cnt,
  output logic          cnt_nz,
  output logic          cnt_last
);

  localparam int          NPTR   = 2;
  localparam logic [AW-1:0] STEP_W = AW'(DW / 8);
  localparam logic [AW-1:0] STEP_B = AW'(1);

  logic [AW-1:0] step;
  logic [AW-1:0] ptr_q [NPTR];
  logic          ptr_wr [NPTR];
  logic          ptr_inc [NPTR];
  logic [CW-1:0] cnt_q, cnt_n;

  assign step       = wide ? STEP_W : STEP_B;
  assign ptr_wr[0]  = wr_src;
  assign ptr_wr[1]  = wr_dst;
  assign ptr_inc[0] = src_inc;
  assign ptr_inc[1] = dst_inc;

  for (genvar i = 0; i < NPTR; i++) begin : g_ptr
    logic [AW-1:0] nxt;
    always_comb begin
      nxt = ptr_q[i];
      if (unit_done && ptr_inc[i])
        nxt = ptr_q[i] + step;
      else if (ptr_wr[i])
        nxt = wr_data[AW-1:0];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        ptr_q[i] <= '0;
      else
        ptr_q[i] <= nxt;
    end
  end

  always_comb begin
    cnt_n = cnt_q;
    if (unit_done)
      cnt_n = cnt_q - CW'(1);
    else if (wr_cnt)
      cnt_n = wr_data[CW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else
      cnt_q <= cnt_n;
  end

  assign src      = ptr_q[0];
  assign dst      = ptr_q[1];
  assign cnt      = cnt_q;
  assign cnt_nz   = (cnt_q != '0);
  assign cnt_last = (cnt_q == CW'(1));

endmodule

// File: rtl/dma_seq.sv
module dma_seq
  import dma_chan_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          burst,
  input  logic          wide,
  input  logic          cnt_last,
  input  logic [AW-1:0] src,
  input  logic [AW-1:0] dst,
  input  logic          bus_gnt,
  input  logic          bus_rdy,
  input  logic [DW-1:0] bus_rdata,
  output logic          bus_req,
  output logic          bus_rd,
  output logic          bus_wr,
  output logic [AW-1:0] bus_addr,
  output logic          bus_word,
  output logic [DW-1:0] bus_wdata,
  output logic          unit_done
);

  seq_state_t    state_q, state_n;
  logic [DW-1:0] data_q, data_n;
  logic          data_en;

  always_comb begin
    state_n   = state_q;
    unit_done = 1'b0;
    data_en   = 1'b0;
    case (state_q)
      SQ_IDLE: if (go) state_n = SQ_REQ;
      SQ_REQ: begin
        if (!go)          state_n = SQ_IDLE;
        else if (bus_gnt) state_n = SQ_RD;
      end
      SQ_RD: if (bus_rdy) begin
        data_en = 1'b1;
        state_n = SQ_WR;
      end
      SQ_WR: if (bus_rdy) begin
        unit_done = 1'b1;
        if (!cnt_last && burst && go) state_n = SQ_RD;
        else                          state_n = SQ_IDLE;
      end
      default: state_n = SQ_IDLE;
    endcase
  end

  assign data_n = wide ? bus_rdata : DW'(bus_rdata[7:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      data_q  <= '0;
    end else begin
      state_q <= state_n;
      if (data_en)
        data_q <= data_n;
    end
  end

  assign bus_req   = (state_q != SQ_IDLE);
  assign bus_rd    = (state_q == SQ_RD);
  assign bus_wr    = (state_q == SQ_WR);
  assign bus_addr  = bus_wr ? dst : src;
  assign bus_word  = wide;
  assign bus_wdata = data_q;

  // R10: no read before the grant
  a_r10_read_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_REQ && !bus_gnt) |=> !bus_rd);

  // R10: a write cycle holds until ready
  a_r10_write_held: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_rdy) |=> (bus_wr && $stable(bus_addr)));

  // R5: a unit that starts reading always reaches its write
  a_r5_unit_completes: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_rdy) |=> bus_wr);

  // R5: once stopped after a unit, nothing more is read
  a_r5_stop_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_rdy && !go) |=> (!bus_rd && !bus_wr));

endmodule

// File: rtl/dma_burst_chan.sv
module dma_burst_chan
  import dma_chan_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [1:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          nmi,
  output logic          bus_req,
  input  logic          bus_gnt,
  output logic [AW-1:0] bus_addr,
  output logic          bus_rd,
  output logic          bus_wr,
  output logic          bus_word,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  input  logic          bus_rdy,
  output logic          done
);

  logic [1:0]    rst_sync_q;
  logic          rst_ni;
  chan_ctrl_t    ctrl;
  logic [AW-1:0] src, dst;
  logic [CW-1:0] cnt;
  logic          cnt_nz, cnt_last;
  logic          unit_done, last_done, go;
  logic          done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rst_sync_q <= 2'b00;
    else
      rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  assign last_done = unit_done && cnt_last;
  assign go        = ctrl.ch_en && ctrl.mst_en && cnt_nz && !(ctrl.burst && nmi);

  dma_ctrl_regs u_ctrl (
    .clk       (clk),
    .rst_n     (rst_ni),
    .wr_en     (reg_we && reg_addr == OFS_CTRL),
    .wr_data   (reg_wdata[CTRL_W-1:0]),
    .nmi       (nmi),
    .last_done (last_done),
    .ctrl      (ctrl)
  );

  dma_addr_path #(.AW(AW), .CW(CW), .DW(DW)) u_path (
    .clk       (clk),
    .rst_n     (rst_ni),
    .wr_src    (reg_we && reg_addr == OFS_SRC),
    .wr_dst    (reg_we && reg_addr == OFS_DST),
    .wr_cnt    (reg_we && reg_addr == OFS_CNT),
    .wr_data   (reg_wdata),
    .unit_done (unit_done),
    .wide      (ctrl.wide),
    .src_inc   (ctrl.src_inc),
    .dst_inc   (ctrl.dst_inc),
    .src       (src),
    .dst       (dst),
    .cnt       (cnt),
    .cnt_nz    (cnt_nz),
    .cnt_last  (cnt_last)
  );

  dma_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_ni),
    .go        (go),
    .burst     (ctrl.burst),
    .wide      (ctrl.wide),
    .cnt_last  (cnt_last),
    .src       (src),
    .dst       (dst),
    .bus_gnt   (bus_gnt),
    .bus_rdy   (bus_rdy),
    .bus_rdata (bus_rdata),
    .bus_req   (bus_req),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_word  (bus_word),
    .bus_wdata (bus_wdata),
    .unit_done (unit_done)
  );

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)
      done_q <= 1'b0;
    else
      done_q <= last_done;
  end
  assign done = done_q;

  always_comb begin
    case (reg_addr)
      OFS_SRC: reg_rdata = 32'(src);
      OFS_DST: reg_rdata = 32'(dst);
      OFS_CNT: reg_rdata = 32'(cnt);
      default: reg_rdata = 32'(ctrl);
    endcase
  end

  // R2: the request only rises with both enables set
  a_r2_req_needs_enables: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(bus_req) |-> $past(ctrl.ch_en && ctrl.mst_en));

  // R9: completion pulse lasts one cycle
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_ni)
    done |=> !done);

endmodule

// File: tb/tb_dma_burst_chan.sv
module tb_dma_burst_chan;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [1:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        nmi;
  logic        bus_req, bus_gnt, bus_rd, bus_wr, bus_word, bus_rdy, done;
  logic [15:0] bus_addr, bus_wdata, bus_rdata;

  always #2 clk = ~clk;

  dma_burst_chan dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .nmi(nmi),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_addr(bus_addr),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_word(bus_word),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rdy(bus_rdy),
    .done(done)
  );

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  // Bus model
  logic [7:0] mem [0:1023];
  logic [7:0] exp_mem [0:1023];
  logic       mem_init;
  logic [7:0] seed;
  logic       slow, phase, gnt_en;
  logic [9:0] ma;

  assign ma        = bus_addr[9:0];
  assign bus_rdy   = !slow || phase;
  assign bus_rdata = bus_word ? {mem[ma + 10'd1], mem[ma]} : {8'h00, mem[ma]};

  function automatic logic [7:0] pat(input int i, input logic [7:0] s);
    return 8'(i * 13 + 5) ^ s;
  endfunction

  always @(posedge clk) begin
    if (mem_init) begin
      for (int i = 0; i < 1024; i++) mem[i] <= pat(i, seed);
    end else if (bus_wr && bus_rdy) begin
      mem[ma] <= bus_wdata[7:0];
      if (bus_word) mem[ma + 10'd1] <= bus_wdata[15:8];
    end
  end

  always @(negedge clk) begin
    phase   <= ~phase;
    bus_gnt <= bus_req && gnt_en;
  end

  // Observation counters
  int rd_cnt = 0, wr_cnt = 0, req_rises = 0, done_cnt = 0;
  logic req_prev = 1'b0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (bus_rd && bus_rdy) rd_cnt <= rd_cnt + 1;
    if (bus_wr && bus_rdy) wr_cnt <= wr_cnt + 1;
    if (done) done_cnt <= done_cnt + 1;
    if (bus_req && !req_prev) req_rises <= req_rises + 1;
    req_prev <= bus_req;
  end

  always @(posedge clk) begin
    if (cyc == 150000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wreg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rreg(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  function automatic logic [31:0] cw(input logic me, ce, di, si, bu, wd);
    return {26'd0, me, ce, di, si, bu, wd};
  endfunction

  // Reference copy built from R8 stepping rules
  task automatic build_exp(input logic [15:0] s, d, input int n, input logic wd, si, di);
    int step;
    step = wd ? 2 : 1;
    for (int i = 0; i < 1024; i++) exp_mem[i] = pat(i, seed);
    for (int k = 0; k < n; k++) begin
      int sa, da;
      sa = (s + (si ? k * step : 0)) % 1024;
      da = (d + (di ? k * step : 0)) % 1024;
      exp_mem[da] = exp_mem[sa];
      if (wd) exp_mem[(da + 1) % 1024] = exp_mem[(sa + 1) % 1024];
    end
  endtask

  function automatic int mem_diffs();
    int n = 0;
    for (int i = 0; i < 1024; i++) if (mem[i] !== exp_mem[i]) n++;
    return n;
  endfunction

  task automatic prep(input logic [15:0] s, d, input int n, input logic [7:0] sd);
    seed = sd;
    @(negedge clk); mem_init = 1'b1;
    @(negedge clk); mem_init = 1'b0;
    wreg(2'd0, 32'(s));
    wreg(2'd1, 32'(d));
    wreg(2'd2, 32'(n));
  endtask

  task automatic wait_done(input int base);
    int t = 0;
    while (done_cnt == base && t < 5000) begin @(negedge clk); t++; end
    repeat (3) @(negedge clk);
  endtask

  // {src, dst, count, word, burst, src_inc, dst_inc, slow}
  localparam int NV = 6;
  localparam logic [44:0] VEC [NV] = '{
    {16'h0010, 16'h0100, 8'd4, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0},
    {16'h0020, 16'h0180, 8'd5, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1},
    {16'h0040, 16'h0200, 8'd3, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
    {16'h0060, 16'h0240, 8'd4, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1},
    {16'h0080, 16'h0280, 8'd3, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0},
    {16'h00A0, 16'h02C0, 8'd1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1}
  };

  initial begin
    logic [31:0] rd;
    int b_rise, b_done, b_wr, b_rd, stop_wr;
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = 2'd0; reg_wdata = '0; nmi = 1'b0;
    mem_init = 1'b0; seed = 8'h00; slow = 1'b0; phase = 1'b0; gnt_en = 1'b1;
    bus_gnt = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // Reset state (R1, R2, R9)
    rreg(2'd3, rd); chk("R1 reset ctrl", rd, 32'h0);
    rreg(2'd2, rd); chk("R1 reset count", rd, 32'h0);
    chk("R2 reset request", {31'd0, bus_req}, 32'h0);
    chk("R9 reset done", {31'd0, done}, 32'h0);

    // Vector table
    for (int v = 0; v < NV; v++) begin
      logic [15:0] s, d;
      int n, step;
      logic wd, bu, si, di;
      {s, d, n[7:0], wd, bu, si, di, slow} = VEC[v];
      n = n & 255;
      step = wd ? 2 : 1;
      prep(s, d, n, 8'(v * 29 + 1));
      build_exp(s, d, n, wd, si, di);
      b_rise = req_rises; b_done = done_cnt;
      wreg(2'd3, cw(1, 1, di, si, bu, wd));
      wait_done(b_done);
      chk($sformatf("R7 R10 vec%0d copy mismatches", v), 32'(mem_diffs()), 0);
      rreg(2'd0, rd); chk($sformatf("R8 vec%0d src end", v), rd, 32'(s + (si ? n * step : 0)));
      rreg(2'd1, rd); chk($sformatf("R8 vec%0d dst end", v), rd, 32'(d + (di ? n * step : 0)));
      rreg(2'd2, rd); chk($sformatf("R9 vec%0d count", v), rd, 0);
      rreg(2'd3, rd); chk($sformatf("R9 vec%0d ctrl", v), rd, cw(1, 0, di, si, bu, wd));
      chk($sformatf("R9 vec%0d done pulses", v), 32'(done_cnt - b_done), 1);
      chk($sformatf("R12 vec%0d request rises", v), 32'(req_rises - b_rise), bu ? 1 : 32'(n));
    end
    slow = 1'b0;

    // R2: master enable off keeps the channel idle
    prep(16'h0300, 16'h0340, 4, 8'h11);
    b_rd = rd_cnt;
    wreg(2'd3, cw(0, 1, 1, 1, 1, 0));
    repeat (10) @(negedge clk);
    chk("R2 no request without master", {31'd0, bus_req}, 0);
    chk("R2 no reads without master", 32'(rd_cnt - b_rd), 0);

    // R10: request waits for grant
    gnt_en = 1'b0;
    build_exp(16'h0300, 16'h0340, 4, 0, 1, 1);
    b_done = done_cnt;
    wreg(2'd3, cw(1, 1, 1, 1, 1, 0));
    repeat (10) @(negedge clk);
    chk("R10 request pending", {31'd0, bus_req}, 1);
    chk("R10 no read before grant", 32'(rd_cnt - b_rd), 0);
    gnt_en = 1'b1;
    wait_done(b_done);
    chk("R10 copy after grant", 32'(mem_diffs()), 0);

    // R3/R5/R6/R7: suspend a word burst, then resume
    prep(16'h0300, 16'h0360, 8, 8'h5A);
    build_exp(16'h0300, 16'h0360, 8, 1, 1, 1);
    b_wr = wr_cnt; b_rd = rd_cnt; b_done = done_cnt;
    wreg(2'd3, cw(1, 1, 1, 1, 1, 1));
    while (wr_cnt - b_wr < 3) @(negedge clk);
    nmi = 1'b1;
    @(negedge clk);
    nmi = 1'b0;
    repeat (8) @(negedge clk);
    stop_wr = wr_cnt - b_wr;
    chk("R5 request dropped", {31'd0, bus_req}, 0);
    chk("R5 unit finished", 32'(rd_cnt - b_rd), 32'(stop_wr));
    rreg(2'd3, rd); chk("R3 R6 suspended ctrl", rd, cw(0, 1, 1, 1, 1, 1));
    rreg(2'd2, rd); chk("R6 saved count", rd, 32'(8 - stop_wr));
    rreg(2'd0, rd); chk("R6 saved src", rd, 32'(16'h0300 + 2 * stop_wr));
    repeat (20) @(negedge clk);
    chk("R5 idle while suspended", 32'(wr_cnt - b_wr), 32'(stop_wr));
    chk("R5 no done while suspended", 32'(done_cnt - b_done), 0);
    wreg(2'd3, cw(1, 1, 1, 1, 1, 1));
    wait_done(b_done);
    chk("R7 resumed copy", 32'(mem_diffs()), 0);
    chk("R7 total writes", 32'(wr_cnt - b_wr), 8);

    // R4: interrupt in cycle-steal mode
    prep(16'h0380, 16'h03A0, 4, 8'h33);
    build_exp(16'h0380, 16'h03A0, 4, 0, 1, 1);
    b_wr = wr_cnt; b_done = done_cnt;
    wreg(2'd3, cw(1, 1, 1, 1, 0, 0));
    while (wr_cnt - b_wr < 1) @(negedge clk);
    nmi = 1'b1;
    @(negedge clk);
    rreg(2'd3, rd); chk("R4 enables kept during nmi", rd, cw(1, 1, 1, 1, 0, 0));
    nmi = 1'b0;
    wait_done(b_done);
    chk("R4 copy completes", 32'(mem_diffs()), 0);
    rreg(2'd3, rd); chk("R4 master kept", rd, cw(1, 0, 1, 1, 0, 0));

    // R11: interrupt on the last write
    prep(16'h0100, 16'h0140, 3, 8'h77);
    build_exp(16'h0100, 16'h0140, 3, 0, 1, 1);
    b_done = done_cnt;
    wreg(2'd3, cw(1, 1, 1, 1, 1, 0));
    @(negedge clk); reg_addr = 2'd2;
    #1;
    while (!(bus_wr && bus_rdy && reg_rdata == 32'd1)) begin @(negedge clk); #1; end
    nmi = 1'b1;
    @(negedge clk);
    nmi = 1'b0;
    wait_done(b_done);
    chk("R11 done pulses", 32'(done_cnt - b_done), 1);
    chk("R11 copy", 32'(mem_diffs()), 0);
    rreg(2'd3, rd); chk("R11 ctrl", rd, cw(0, 0, 1, 1, 1, 0));

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule